// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block watches a row of already synchronized, polarity-corrected GPIO data bits and records configurable transitions on them. Each pin carries a two-bit sensitivity field that selects no edge, the rising edge, the falling edge or either edge. A detected edge always sets the pin's bit in an event status register. When the pin is an unmasked input, the edge also sets the pin's bit in an interrupt source register. An active-low interrupt line stays asserted while any source bit is set.

Software acknowledges events by writing ones to either the source or the status register. A one written to a bit clears that bit in both registers. Rewriting a pin's sensitivity field to a different value discards that pin's latched event. Edge detection compares each bit's value in the current clock with its value in the previous clock. Register writes take effect at the clock edge that samples them. Reads are combinational on the read address.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset the mask register (address 0x9) reads all ones, the sense registers (0xA, 0xB), the source register (0xC) and the status register (0xD) read zero, and intN is high.
- R2: A sensitivity field uses this encoding: 00 means no edge, 01 means rising, 10 means falling and 11 means either edge. A matching transition of pinData sets the pin's status bit at the clock edge that samples the new value. A level that stays the same sets nothing.
- R3: The sense register at 0xA holds the fields for the upper half of the pins. Bits [2k+1:2k] belong to pin HALF+k. The sense register at 0xB holds the lower half in the same layout, so its bits [2k+1:2k] belong to pin k.
- R4: A status bit is set by its pin's configured edge whatever the pin's mask bit and direction bit are.
- R5: A source bit is set only when the pin's mask bit is 0 (1 blocks) and its pinIsInput bit is 1. A source bit is never set without the matching status bit.
- R6: intN is low exactly when at least one source bit is set.
- R7: Writing a 1 to a bit of the source register, or of the status register, clears that bit in both registers. Bits written as 0 are unchanged.
- R8: If a write-one clear and a new configured edge hit the same bit in the same cycle, the edge wins and the bit stays set.
- R9: A write that changes a pin's sensitivity field clears that pin's status and source bits. This clear beats an edge in the same cycle. Rewriting the same field value leaves both bits unchanged.
- R10: Registers read back at their addresses. An unmapped read address returns zero, and a write to an unmapped address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write address |
| wrData | input | NUM_PINS | Register write data |
| rdAddr | input | ADDR_W | Register read address |
| rdData | output | NUM_PINS | Register read data (combinational) |
| pinData | input | NUM_PINS | Synchronized, polarity-corrected pin values |
| pinIsInput | input | NUM_PINS | 1 means the pin is configured as an input |
| intN | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its defaults of eight pins and a four-bit address. With these values both sense registers are populated, and each of the four encodings can be placed on separate pins of one register and exercised by a single transition. Because of the width, a mix of masked, unmasked, output and input pins can be driven in one step. The width also lets edge-versus-clear and edge-versus-reconfiguration collisions be staged on one bit while neighbouring bits act as controls.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_OFF  = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_ANY  = 2'b11
  } senseSel_t;

  localparam int ADDR_MASK      = 9;
  localparam int ADDR_SENSE_HI  = 10;
  localparam int ADDR_SENSE_LO  = 11;
  localparam int ADDR_SOURCE    = 12;
  localparam int ADDR_STATUS    = 13;

  typedef struct packed {
    logic maskWr;
    logic senseHiWr;
    logic senseLoWr;
    logic srcClrWr;
    logic statClrWr;
  } ctrlStrobes_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int REG_W  = 8
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [REG_W-1:0]  maskVal,
  input  logic [REG_W-1:0]  senseHiVal,
  input  logic [REG_W-1:0]  senseLoVal,
  input  logic [REG_W-1:0]  sourceVal,
  input  logic [REG_W-1:0]  statusVal,
  output ctrlStrobes_t      strb,
  output logic [REG_W-1:0]  rdData
);

  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(ADDR_MASK);
  localparam logic [ADDR_W-1:0] A_SHI  = ADDR_W'(ADDR_SENSE_HI);
  localparam logic [ADDR_W-1:0] A_SLO  = ADDR_W'(ADDR_SENSE_LO);
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(ADDR_SOURCE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STATUS);

  // write decode into strobes for the datapath
  always_comb begin
    strb = '0;
    if (wrEn) begin
      unique case (wrAddr)
        A_MASK:  strb.maskWr    = 1'b1;
        A_SHI:   strb.senseHiWr = 1'b1;
        A_SLO:   strb.senseLoWr = 1'b1;
        A_SRC:   strb.srcClrWr  = 1'b1;
        A_STAT:  strb.statClrWr = 1'b1;
        default: strb = '0;
      endcase
    end
  end

  // read mux, unmapped addresses return zero (R10)
  always_comb begin
    unique case (rdAddr)
      A_MASK:  rdData = maskVal;
      A_SHI:   rdData = senseHiVal;
      A_SLO:   rdData = senseLoVal;
      A_SRC:   rdData = sourceVal;
      A_STAT:  rdData = statusVal;
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strb,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [NUM_PINS-1:0] pinData,
  input  logic [NUM_PINS-1:0] pinIsInput,
  output logic [NUM_PINS-1:0] maskReg,
  output logic [NUM_PINS-1:0] senseHiVal,
  output logic [NUM_PINS-1:0] senseLoVal,
  output logic [NUM_PINS-1:0] statusReg,
  output logic [NUM_PINS-1:0] sourceReg,
  output logic                intN
);

  localparam int HALF = NUM_PINS / 2;

  logic [NUM_PINS-1:0][1:0] senseCfg;
  logic [NUM_PINS-1:0]      prevData;
  logic [NUM_PINS-1:0]      hitVec;
  logic [NUM_PINS-1:0]      autoClr;
  logic [NUM_PINS-1:0]      clrBits;
  logic [NUM_PINS-1:0]      srcHit;
  logic [NUM_PINS-1:0]      statusNext;
  logic [NUM_PINS-1:0]      sourceNext;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin
      logic       fieldWr;
      logic [1:0] newField;
      logic       riseNow;
      logic       fallNow;

      if (gi >= HALF) begin : g_hi
        assign fieldWr  = strb.senseHiWr;
        assign newField = wrData[2*(gi-HALF) +: 2];
        assign senseHiVal[2*(gi-HALF) +: 2] = senseCfg[gi];
      end else begin : g_lo
        assign fieldWr  = strb.senseLoWr;
        assign newField = wrData[2*gi +: 2];
        assign senseLoVal[2*gi +: 2] = senseCfg[gi];
      end

      assign riseNow = pinData[gi] & ~prevData[gi];
      assign fallNow = ~pinData[gi] & prevData[gi];

      always_comb begin
        unique case (senseCfg[gi])
          SENSE_RISE: hitVec[gi] = riseNow;
          SENSE_FALL: hitVec[gi] = fallNow;
          SENSE_ANY:  hitVec[gi] = riseNow | fallNow;
          default:    hitVec[gi] = 1'b0;
        endcase
      end

      // a changed field discards the latched event (R9)
      assign autoClr[gi] = fieldWr && (newField != senseCfg[gi]);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        senseCfg[gi] <= SENSE_OFF;
        else if (fieldWr) senseCfg[gi] <= newField;
      end
    end
  endgenerate

  assign clrBits    = (strb.srcClrWr || strb.statClrWr) ? wrData : '0;
  assign srcHit     = hitVec & ~maskReg & pinIsInput;
  assign statusNext = ((statusReg & ~clrBits) | hitVec) & ~autoClr;
  assign sourceNext = ((sourceReg & ~clrBits) | srcHit) & ~autoClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg   <= '1;
      prevData  <= '0;
      statusReg <= '0;
      sourceReg <= '0;
    end else begin
      prevData  <= pinData;
      statusReg <= statusNext;
      sourceReg <= sourceNext;
      if (strb.maskWr) maskReg <= wrData;
    end
  end

  assign intN = ~|sourceReg;

  // source bits only ever appear on pins that were unmasked inputs
  assert_src_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((sourceReg & ~$past(sourceReg)) &
              ($past(maskReg) | ~$past(pinIsInput))) == '0);

  assert_src_in_status_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sourceReg & ~statusReg) == '0);

  assert_clear_takes_R7: assert property (@(posedge clk) disable iff (!rstN)
    (clrBits & ~hitVec) != '0 |=>
      ((statusReg | sourceReg) & $past(clrBits & ~hitVec)) == '0);

  assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hitVec & ~autoClr) != '0 |=>
      (statusReg & $past(hitVec & ~autoClr)) == $past(hitVec & ~autoClr));

  assert_auto_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    autoClr != '0 |=> ((statusReg | sourceReg) & $past(autoClr)) == '0);

  assert_intn_tracks_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intN) |-> $past(srcHit) != '0);

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [NUM_PINS-1:0] rdData,
  input  logic [NUM_PINS-1:0] pinData,
  input  logic [NUM_PINS-1:0] pinIsInput,
  output logic                intN
);

  ctrlStrobes_t        strb;
  logic [NUM_PINS-1:0] maskReg;
  logic [NUM_PINS-1:0] senseHiVal;
  logic [NUM_PINS-1:0] senseLoVal;
  logic [NUM_PINS-1:0] statusReg;
  logic [NUM_PINS-1:0] sourceReg;

  gpio_irq_ctrl #(.ADDR_W(ADDR_W), .REG_W(NUM_PINS)) u_ctrl (
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .rdAddr     (rdAddr),
    .maskVal    (maskReg),
    .senseHiVal (senseHiVal),
    .senseLoVal (senseLoVal),
    .sourceVal  (sourceReg),
    .statusVal  (statusReg),
    .strb       (strb),
    .rdData     (rdData)
  );

  gpio_irq_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (wrData),
    .pinData    (pinData),
    .pinIsInput (pinIsInput),
    .maskReg    (maskReg),
    .senseHiVal (senseHiVal),
    .senseLoVal (senseLoVal),
    .statusReg  (statusReg),
    .sourceReg  (sourceReg),
    .intN       (intN)
  );

endmodule

// File: tb/gpio_edge_irq_test.sv
module gpio_edge_irq_test;

  localparam int NP = 8;
  localparam int AW = 4;
  localparam logic [AW-1:0] A_MASK = 4'h9;
  localparam logic [AW-1:0] A_SHI  = 4'hA;
  localparam logic [AW-1:0] A_SLO  = 4'hB;
  localparam logic [AW-1:0] A_SRC  = 4'hC;
  localparam logic [AW-1:0] A_STAT = 4'hD;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [NP-1:0] wrData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [NP-1:0] rdData;
  logic [NP-1:0] pinData = '0;
  logic [NP-1:0] pinIsInput = '1;
  logic          intN;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  gpio_edge_irq #(.NUM_PINS(NP), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .pinData(pinData),
    .pinIsInput(pinIsInput), .intN(intN)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic regWrite(input logic [AW-1:0] a, input logic [NP-1:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic expectReg(input logic [AW-1:0] a, input logic [NP-1:0] exp,
                           input string tag);
    rdAddr = a;
    #0.5;
    total++;
    if (rdData !== exp) begin
      bad++;
      $display("FAIL %s addr=%0h actual=%02h expected=%02h", tag, a, rdData, exp);
    end
  endtask

  task automatic expectIntN(input logic exp, input string tag);
    total++;
    if (intN !== exp) begin
      bad++;
      $display("FAIL %s intN actual=%0b expected=%0b", tag, intN, exp);
    end
  endtask

  task automatic clearAll();
    regWrite(A_STAT, 8'hFF);
  endtask

  task automatic testReset();
    expectReg(A_MASK, 8'hFF, "R1 mask");
    expectReg(A_SHI, 8'h00, "R1 senseHi");
    expectReg(A_SLO, 8'h00, "R1 senseLo");
    expectReg(A_SRC, 8'h00, "R1 source");
    expectReg(A_STAT, 8'h00, "R1 status");
    expectIntN(1'b1, "R1");
    expectReg(4'h3, 8'h00, "R10 unmapped read");
  endtask

  task automatic testEncoding();
    // low pins: p0 rise, p1 fall, p2 either, p3 none
    regWrite(A_SLO, 8'h39);
    expectReg(A_SLO, 8'h39, "R10 senseLo readback");
    pinData = 8'h0F; tick();
    expectReg(A_STAT, 8'h05, "R2 rise/either");
    tick(); tick();
    expectReg(A_STAT, 8'h05, "R2 steady level");
    clearAll();
    pinData = 8'h00; tick();
    expectReg(A_STAT, 8'h06, "R2 fall/either");
    expectReg(A_SRC, 8'h00, "R4 masked no source");
    expectIntN(1'b1, "R4");
    clearAll();
    // high pins: p7 rise, p4 fall
    regWrite(A_SHI, 8'h42);
    pinData = 8'hF0; tick();
    expectReg(A_STAT, 8'h80, "R3 pin7 rising");
    clearAll();
    pinData = 8'h00; tick();
    expectReg(A_STAT, 8'h10, "R3 pin4 falling");
    clearAll();
  endtask

  task automatic testMasking();
    regWrite(A_SHI, 8'hFF);
    regWrite(A_SLO, 8'hFF);
    regWrite(A_MASK, 8'hF0);
    pinIsInput = 8'hF5;
    pinData = 8'hFF; tick();
    expectReg(A_STAT, 8'hFF, "R4 status all pins");
    expectReg(A_SRC, 8'h05, "R5 unmasked inputs only");
    expectIntN(1'b0, "R6 asserted");
  endtask

  task automatic testClear();
    regWrite(A_SRC, 8'h01);
    expectReg(A_SRC, 8'h04, "R7 source w1c");
    expectReg(A_STAT, 8'hFE, "R7 source clears status");
    regWrite(A_STAT, 8'h00);
    expectReg(A_STAT, 8'hFE, "R7 zero write");
    regWrite(A_STAT, 8'h04);
    expectReg(A_SRC, 8'h00, "R7 status clears source");
    expectReg(A_STAT, 8'hFA, "R7 status w1c");
    expectIntN(1'b1, "R6 released");
    clearAll();
  endtask

  task automatic testEdgeWins();
    pinData = 8'hFE; tick();
    expectReg(A_SRC, 8'h01, "R8 setup");
    pinData = 8'hFF;
    regWrite(A_STAT, 8'h03);
    expectReg(A_STAT, 8'h01, "R8 edge beats clear");
    expectReg(A_SRC, 8'h01, "R8 source kept");
    expectIntN(1'b0, "R8");
    clearAll();
  endtask

  task automatic testAutoClear();
    pinData = 8'hFE; tick();
    regWrite(A_SLO, 8'hFF);
    expectReg(A_STAT, 8'h01, "R9 same field keeps");
    regWrite(A_SLO, 8'hFE);
    expectReg(A_STAT, 8'h00, "R9 changed field clears");
    expectReg(A_SRC, 8'h00, "R9 source cleared");
    expectIntN(1'b1, "R9");
    pinData = 8'hFC;
    regWrite(A_SLO, 8'hF2);
    expectReg(A_STAT, 8'h00, "R9 clear beats edge");
    expectReg(A_SLO, 8'hF2, "R10 senseLo readback");
  endtask

  task automatic testUnmapped();
    regWrite(4'h3, 8'hFF);
    expectReg(A_MASK, 8'hF0, "R10 mask untouched");
    expectReg(A_SHI, 8'hFF, "R10 senseHi untouched");
    expectReg(A_SLO, 8'hF2, "R10 senseLo untouched");
    expectReg(A_STAT, 8'h00, "R10 status untouched");
    expectReg(4'h3, 8'h00, "R10 unmapped read");
  endtask

  initial begin
    pinData = 8'hFF;
    tick(); tick();
    rstN = 1'b1;
    tick();
    pinData = 8'h00;
    tick();
    testReset();
    testEncoding();
    testMasking();
    testClear();
    testEdgeWins();
    testAutoClear();
    testUnmapped();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule